// File: doc/BRIEF.md
# Over-Current Pulse-Skip Supervisor

This block watches one channel of a synchronous buck controller for over-current. A digitized current-limit comparator flag arrives asynchronously; the block brings it into the clock domain and samples it once per switching period, at the strobe that marks the start of each oscillator cycle. The first limit event does not shut anything down. Instead, the high-side drive is held off for a fixed run of switching cycles, after which the block watches a second run of cycles for a repeat. Only a repeat inside that second run sets a sticky fault that holds the drive off and pulls power-good low.

Cycles are numbered from the event: the cycle that begins at the strobe where the limit was seen is cycle 1. With the default parameters, cycles 1 to 8 are skipped, and cycles 9 to 16 are watched with the drive free to switch. If no repeat arrives, the block is idle again from cycle 17. A fault stays set until enable is taken low or the power-on reset is applied.

Top module: `ocp_skip_latch`

## Requirements
- R1: The raw limit flag passes through two flip-flops before use, and only its value at a cycle-start strobe counts; a raw pulse that has ended before the strobe sample has no effect on hs_inhibit or fault.
- R2: While idle and enabled, a sampled limit flag at a strobe starts an event; hs_inhibit is high from the clock after that strobe (cycle 1).
- R3: hs_inhibit stays high through cycles 1 to 8 of an event and falls at the strobe that starts cycle 9 when no fault is set.
- R4: A limit flag sampled at the strobes that start cycles 2 to 8 neither sets fault nor extends the skip run.
- R5: A limit flag sampled at the strobe that starts any of cycles 9 to 16 sets fault on the clock after that strobe; hs_inhibit stays high while fault is set.
- R6: With no repeat in cycles 9 to 16 the block is idle from cycle 17; a limit flag at the strobe starting cycle 17 starts a new event (hs_inhibit high again) and does not set fault.
- R7: Once set, fault and hs_inhibit stay high while enable is high, whatever the limit flag and strobe do.
- R8: While enable is low, fault and the cycle count clear on the next clock, hs_inhibit is high, and no limit flag can set fault.
- R9: After rst_n is low, fault is 0 and the block is idle; with enable high hs_inhibit is 0.
- R10: pgood_out equals pg_in while fault is 0 and is 0 while fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset |
| enable | input | 1 | Channel enable; low clears a fault |
| cyc_start | input | 1 | One-clock strobe at the start of each oscillator cycle |
| ilim_raw | input | 1 | Asynchronous current-limit comparator flag |
| pg_in | input | 1 | Output-voltage window comparator result |
| hs_inhibit | output | 1 | High-side drive suppressed for the current cycle |
| fault | output | 1 | Latched over-current fault, shuts the chip down |
| pgood_out | output | 1 | Power-good, forced low by a fault |

## Verification
On every clock the embedded properties check that a fault only appears after a strobe that saw the limit flag inside the watch run, that it sticks while enabled and clears when disabled, that the count moves only on strobes, that a fresh event inhibits the drive at once, and that power-good follows the fault. What only the bench scenarios show is the cycle arithmetic: that the repeat at cycle 9 and at cycle 16 both latch, that a repeat at cycle 17 starts a new skip run instead, that flags in cycles 2 to 8 are ignored, and that a short raw pulse between strobes is missed.

// File: rtl/ocp_skip_latch.sv
module ocp_skip_latch #(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cyc_start,
  input  logic ilim_raw,
  input  logic pg_in,
  output logic hs_inhibit,
  output logic fault,
  output logic pgood_out
);
  localparam int LAST = SKIP_CYCLES + WATCH_CYCLES;
  localparam int CW   = $clog2(LAST + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          lim_s, in_skip, watch_next;

  assign lim_s      = sync_q[1];
  assign in_skip    = (cnt != '0) && (cnt <= CW'(SKIP_CYCLES));
  assign watch_next = (cnt >= CW'(SKIP_CYCLES)) && (cnt < CW'(LAST));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ilim_raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (cyc_start && !fault) begin
      if (cnt == '0 || cnt == CW'(LAST))
        cnt <= lim_s ? CW'(1) : '0;
      else if (watch_next && lim_s) begin
        fault <= 1'b1;
        cnt   <= '0;
      end else
        cnt <= cnt + CW'(1);
    end
  end

  assign hs_inhibit = !enable || fault || in_skip;
  assign pgood_out  = pg_in && !fault;

  a_r5_fault_only_in_watch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(cyc_start && lim_s && watch_next && enable));
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && enable) |=> fault);
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fault && cnt == '0));
  a_r2_event_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fault && cnt == '0 && cyc_start && lim_s) |=> (hs_inhibit || !enable));
  a_r3_count_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cyc_start) |=> $stable(cnt));
  a_r10_pgood_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !pgood_out);
endmodule

// File: tb/ocp_skip_latch_test.sv
module ocp_skip_latch_test;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cyc_start = 1'b0, ilim_raw = 1'b0, pg_in = 1'b1;
  logic hs_inhibit, fault, pgood_out;
  int checks = 0, fails = 0;
  int mc = 0;
  bit mf = 0, men = 0;

  always #4 clk = ~clk;

  ocp_skip_latch uut (.clk(clk), .rst_n(rst_n), .enable(enable), .cyc_start(cyc_start),
    .ilim_raw(ilim_raw), .pg_in(pg_in), .hs_inhibit(hs_inhibit), .fault(fault),
    .pgood_out(pgood_out));

  function automatic bit exp_inh();
    return !men || mf || (mc >= 1 && mc <= 8);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit lim);
    if (!men) begin mc = 0; mf = 0; end
    else if (mf) ;
    else if (mc == 0 || mc == 16) mc = lim ? 1 : 0;
    else if (mc >= 8 && lim) begin mf = 1; mc = 0; end
    else mc++;
  endtask

  task automatic osc(input bit lim, input bit en, input bit pg, input string tag);
    @(negedge clk);
    ilim_raw = lim; enable = en; pg_in = pg; men = en;
    repeat (3) @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    model_step(lim);
    chk(hs_inhibit, exp_inh(), tag);
    chk(fault, mf, tag);
    chk(pgood_out, pg && !mf, {tag, " R10"});
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) osc(0, 1, 1, tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    enable = 1'b1; men = 1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(fault, 1'b0, "R9 reset fault");
    chk(hs_inhibit, 1'b0, "R9 reset inhibit");
    chk(pgood_out, 1'b1, "R9 reset pgood");

    // R1: short raw pulse between strobes
    @(negedge clk); ilim_raw = 1'b1;
    @(negedge clk); ilim_raw = 1'b0;
    osc(0, 1, 1, "R1 glitch missed");

    // R2/R3/R6: single event that recovers
    osc(1, 1, 1, "R2 trigger");
    chk(hs_inhibit, 1'b1, "R2 inhibit cycle1");
    for (int k = 2; k <= 8; k++) osc(0, 1, 1, "R3 skip run");
    chk(hs_inhibit, 1'b1, "R3 cycle8 inhibit");
    osc(0, 1, 1, "R3 cycle9");
    chk(hs_inhibit, 1'b0, "R3 released at cycle9");
    quiet(10, "R6 recover");
    chk(fault, 1'b0, "R6 no fault");

    // R4: flags inside skip run ignored, then R5 repeat at cycle 9
    osc(1, 1, 1, "R2 trigger");
    for (int k = 2; k <= 8; k++) osc(k % 2, 1, 1, "R4 ignored in skip");
    chk(fault, 1'b0, "R4 no fault in skip");
    osc(1, 1, 1, "R5 repeat cycle9");
    chk(fault, 1'b1, "R5 latch cycle9");
    for (int k = 0; k < 4; k++) osc(k % 2, 1, 0, "R7 sticky");
    chk(hs_inhibit, 1'b1, "R7 inhibit held");
    osc(0, 0, 1, "R8 disable clears");
    chk(fault, 1'b0, "R8 fault cleared");
    osc(1, 0, 1, "R8 no set when disabled");
    chk(fault, 1'b0, "R8 still clear");

    // R5: repeat at cycle 16
    osc(1, 1, 1, "R2 trigger");
    for (int k = 2; k <= 15; k++) osc(0, 1, 1, "R5 wait");
    osc(1, 1, 1, "R5 repeat cycle16");
    chk(fault, 1'b1, "R5 latch cycle16");
    osc(0, 0, 1, "R8 clear");

    // R6: repeat at cycle 17 restarts
    osc(1, 1, 1, "R2 trigger");
    for (int k = 2; k <= 16; k++) osc(0, 1, 1, "R6 wait");
    osc(1, 1, 1, "R6 repeat cycle17");
    chk(fault, 1'b0, "R6 no latch cycle17");
    chk(hs_inhibit, 1'b1, "R6 new event inhibit");
    quiet(17, "R6 drain");

    // random mix
    for (int i = 0; i < 500; i++) begin
      bit lim, en, pg;
      lim = ($urandom % 6) == 0;
      en  = ($urandom % 40) != 0;
      pg  = ($urandom % 4) != 0;
      osc(lim, en, pg, "R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule